// File: doc/BRIEF.md
# Priority Address Window Translator

This block turns a local-bus address into a downstream bus address through a small set of programmable apertures. Each aperture is held in two registers. A placement register gives the local base address, an enable bit and a power-of-two size. A target register gives the downstream base address and the kind of access: memory, I/O, configuration or messaging. Software can rewrite both registers through a single-cycle write port while traffic flows.

Each request is compared against every enabled aperture. When several apertures claim the same address, the one with the lowest index supplies the translation. Software relies on this: it can enlarge aperture 0 to cover aperture 1, move aperture 1 somewhere else (for example onto a 16 MB configuration area), and then shrink aperture 0 again to expose it. The result of each request appears on registered outputs one cycle after the request. The outputs are the translated address, the access kind, the index of the winning aperture and a miss flag.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every aperture is disabled, so any request returns a miss, and `out_valid` and `out_miss` read 0 until the first request.
- R2: A request presented with `req_valid` high gives `out_valid` high one cycle later with its result. A cycle without a request gives `out_valid` low one cycle later.
- R3: Placement register layout: bits [31:20] are the local base, bit 8 is the enable bit and bits [4:0] are k, the log2 of the aperture size. Any k below 20 is treated as 20. An address hits when the aperture is enabled and the address equals the base in every bit at position k or above. This supports 16 MB (k=24), 256 MB (k=28) and 512 MB (k=29) apertures.
- R4: On a hit, the translated address takes bits at position k and above from the target register, and takes the bits below k from the request address.
- R5: When several enabled apertures hit, the lowest index wins, and `out_idx` reports that index.
- R6: When no enabled aperture hits, `out_miss` is 1, `out_addr` is 0, `out_idx` is 0 and `out_type` is memory (0).
- R7: For apertures 0 and 1, target register bits [1:0] select the access kind, which appears on `out_type`: 0 memory, 1 I/O, 2 configuration, 3 messaging.
- R8: The last aperture (index 2) serves only I/O or messaging. Target bit 0 selects messaging (1) or I/O (0), and target bit 1 has no effect on its access kind.
- R9: When the winning aperture is of configuration kind, bits [1:0] of the translated address are 00. The bus, device, function and register fields in bits 23:2 pass through unchanged.
- R10: A register write takes effect for the first request in a later cycle. A request in the same cycle as the write is translated with the settings from before the write.
- R11: Write port: `wr_sel` 0 writes the placement register and 1 writes the target register of aperture `wr_win`. A write with `wr_win` equal to 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Aperture index for the write |
| wr_sel | input | 1 | 0 placement register, 1 target register |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Local-bus address of the request |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 32 | Translated address (0 on a miss) |
| out_type | output | 2 | Access kind: 0 memory, 1 I/O, 2 configuration, 3 messaging |
| out_idx | output | 2 | Index of the winning aperture |
| out_miss | output | 1 | No enabled aperture matched |

## Verification
The assertions assume that `req_valid` and `rst` are never unknown. They also assume that the outputs are only read while `out_valid` is high, since the result registers hold stale values in idle cycles. The stimulus changes the inputs only on falling edges, so every request and write is stable for a whole cycle. The sweeps walk the address through the region below, between, across and above the apertures in several window layouts. This includes the layout in which aperture 0 covers aperture 1, and writes that land in the same cycle as a request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_MEM = 2'd0,
    ACC_IO  = 2'd1,
    ACC_CFG = 2'd2,
    ACC_MSG = 2'd3
  } acc_e;

  // Enable bit position inside a placement register
  localparam int BASE_EN_BIT = 8;
endpackage

// File: rtl/xlate_window.sv
module xlate_window
  import xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 20,
  parameter bit IS_LAST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base,
  input  logic              wr_map,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr,
  output acc_e              acc
);
  localparam int SIZE_W = $clog2(ADDR_W);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] map_q;
  logic [SIZE_W-1:0] size_raw;
  logic [SIZE_W-1:0] size_eff;
  logic [ADDR_W-1:0] lo_mask;
  logic [ADDR_W-1:0] xa;

  // Placement and target registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      map_q  <= '0;
    end else begin
      if (wr_base) base_q <= wr_data;
      if (wr_map)  map_q  <= wr_data;
    end
  end

  // Aperture size with a floor at the register granularity
  always_comb begin
    size_raw = base_q[SIZE_W-1:0];
    size_eff = (int'(size_raw) < MIN_LOG2) ? SIZE_W'(MIN_LOG2) : size_raw;
    lo_mask  = (ADDR_W'(1) << size_eff) - ADDR_W'(1);
    hit      = base_q[BASE_EN_BIT] && (((req_addr ^ base_q) & ~lo_mask) == '0);
  end

  // Access kind: last aperture restricted to I/O or messaging
  generate
    if (IS_LAST) begin : g_last
      always_comb acc = map_q[0] ? ACC_MSG : ACC_IO;
    end else begin : g_any
      always_comb acc = acc_e'(map_q[1:0]);
    end
  endgenerate

  always_comb begin
    xa = (map_q & ~lo_mask) | (req_addr & lo_mask);
    if (acc == ACC_CFG) xa[1:0] = 2'b00;
    xaddr = xa;
  end
endmodule

// File: rtl/xlate_prio_sel.sv
module xlate_prio_sel
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_WIN-1:0] hit,
  input  logic [ADDR_W-1:0] xaddr [NUM_WIN],
  input  acc_e              acc   [NUM_WIN],
  output logic              any_hit,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [ADDR_W-1:0] sel_addr,
  output acc_e              sel_acc
);
  // Scan from the top down so the lowest index overwrites the rest
  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_addr = '0;
    sel_acc  = ACC_MEM;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        any_hit  = 1'b1;
        sel_idx  = IDX_W'(w);
        sel_addr = xaddr[w];
        sel_acc  = acc[w];
      end
    end
  end

  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (hit[sel_idx] && ((hit & ((NUM_WIN'(1) << sel_idx) - NUM_WIN'(1))) == '0))); // R5
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_WIN  = 3,
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 20,
  localparam int IDX_W   = $clog2(NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_win,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_type,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_miss
);
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_xaddr [NUM_WIN];
  acc_e               win_acc   [NUM_WIN];
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [ADDR_W-1:0]  sel_addr;
  acc_e               sel_acc;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic wb, wm;
      assign wb = wr_en && (wr_win == IDX_W'(w)) && !wr_sel;
      assign wm = wr_en && (wr_win == IDX_W'(w)) &&  wr_sel;
      xlate_window #(
        .ADDR_W  (ADDR_W),
        .MIN_LOG2(MIN_LOG2),
        .IS_LAST (w == NUM_WIN - 1)
      ) u_win (
        .clk     (clk),
        .rst     (rst),
        .wr_base (wb),
        .wr_map  (wm),
        .wr_data (wr_data),
        .req_addr(req_addr),
        .hit     (win_hit[w]),
        .xaddr   (win_xaddr[w]),
        .acc     (win_acc[w])
      );
    end
  endgenerate

  xlate_prio_sel #(
    .NUM_WIN(NUM_WIN),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .hit     (win_hit),
    .xaddr   (win_xaddr),
    .acc     (win_acc),
    .any_hit (any_hit),
    .sel_idx (sel_idx),
    .sel_addr(sel_addr),
    .sel_acc (sel_acc)
  );

  // Registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_type  <= ACC_MEM;
      out_idx   <= '0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= sel_addr;
        out_type <= sel_acc;
        out_idx  <= sel_idx;
        out_miss <= !any_hit;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R2
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_miss) |-> (out_addr == '0 && out_idx == '0 && out_type == ACC_MEM)); // R6
  AST_CFG_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_miss && out_type == ACC_CFG) |-> (out_addr[1:0] == 2'b00)); // R9
  AST_LAST_KIND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_miss && out_idx == IDX_W'(NUM_WIN - 1)) |->
      (out_type == ACC_IO || out_type == ACC_MSG)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx < IDX_W'(NUM_WIN))); // R5
endmodule

// File: tb/addr_window_xlate_tb.sv
`timescale 1ns/1ps
module addr_window_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_win = '0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [1:0]  out_type;
  logic [1:0]  out_idx;
  logic        out_miss;

  int checks = 0;
  int errors = 0;
  logic [31:0] mb [3];
  logic [31:0] mm [3];

  always #2.5 clk = ~clk;

  addr_window_xlate u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_type(out_type),
    .out_idx(out_idx), .out_miss(out_miss)
  );

  // Expected result {valid, miss, idx, type, addr} from the requirements
  function automatic logic [37:0] expect_of(input logic [31:0] a);
    logic [31:0] lo, xa;
    logic [1:0]  ty;
    int k;
    for (int w = 0; w < 3; w++) begin
      k  = int'(mb[w][4:0]);
      if (k < 20) k = 20;
      lo = (32'd1 << k) - 32'd1;
      if (mb[w][8] && (((a ^ mb[w]) & ~lo) == 32'd0)) begin
        xa = (mm[w] & ~lo) | (a & lo);
        ty = (w == 2) ? (mm[w][0] ? 2'd3 : 2'd1) : mm[w][1:0];
        if (ty == 2'd2) xa[1:0] = 2'b00;
        return {1'b1, 1'b0, 2'(w), ty, xa};
      end
    end
    return {1'b1, 1'b1, 2'd0, 2'd0, 32'd0};
  endfunction

  task automatic chk(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] win, input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = win; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (win < 2'd3) begin
      if (sel) mm[win] = d; else mb[win] = d;
    end
  endtask

  task automatic do_req(input logic [31:0] a, input string tag);
    logic [37:0] e;
    e = expect_of(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {out_valid, out_miss, out_idx, out_type, out_addr}, e);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] a;
    for (int i = 0; i < 80; i++) begin
      a = 32'h3F00_0000 + 32'(i) * 32'h0080_0000 + ((32'(i) * 32'h0001_3579) & 32'h007F_FFFF);
      do_req(a, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [37:0] e;
    for (int w = 0; w < 3; w++) begin mb[w] = '0; mm[w] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state then miss everywhere
    chk("R1 reset outputs", {36'd0, out_valid, out_miss}, 38'd0);
    do_req(32'h4000_0000, "R1 miss after reset");
    sweep("R1 R6 all disabled");

    // R2: idle cycle drops out_valid
    @(negedge clk);
    chk("R2 idle", {37'd0, out_valid}, 38'd0);

    // Default layout (R3 R4 R7 R8): kind 2 on last aperture must become I/O
    wr(2'd0, 1'b0, 32'h4000_0000 | 32'h100 | 32'd28);
    wr(2'd0, 1'b1, 32'h8000_0000 | 32'd0);
    wr(2'd1, 1'b0, 32'h5000_0000 | 32'h100 | 32'd28);
    wr(2'd1, 1'b1, 32'h9000_0000 | 32'd1);
    wr(2'd2, 1'b0, 32'h6000_0000 | 32'h100 | 32'd24);
    wr(2'd2, 1'b1, 32'h0A00_0000 | 32'd2);
    sweep("R3 R4 R7 R8 default layout");
    do_req(32'h4FFF_FFFF, "R3 top edge of 256MB");
    do_req(32'h60FF_FFFF, "R3 top edge of 16MB");
    do_req(32'h6100_0000, "R6 just past 16MB");

    // Configuration layout: enlarge aperture 0 then retarget aperture 1 (R5 R9)
    wr(2'd0, 1'b0, 32'h4000_0000 | 32'h100 | 32'd29);
    do_req(32'h5000_1234, "R5 aperture 0 covers aperture 1");
    wr(2'd1, 1'b0, 32'h6100_0000 | 32'h100 | 32'd24);
    wr(2'd1, 1'b1, 32'h0000_0000 | 32'd2);
    sweep("R5 R9 config layout");
    do_req(32'h61AB_CDEF, "R9 config low bits cleared");

    // R11: index 3 writes change nothing
    wr(2'd3, 1'b0, 32'h0000_0000 | 32'h100 | 32'd31);
    wr(2'd3, 1'b1, 32'hFFFF_FFFF);
    sweep("R11 ignored index");

    // R8: messaging on the last aperture, and R3 size floor
    wr(2'd2, 1'b0, 32'h7000_0000 | 32'h100 | 32'd3);
    wr(2'd2, 1'b1, 32'h0B00_0000 | 32'd1);
    do_req(32'h700F_FFFF, "R3 R8 floor hit messaging");
    do_req(32'h7010_0000, "R3 floor miss");

    // R10: write in the same cycle as a request uses old settings
    e = expect_of(32'h4000_0010);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4000_0010;
    wr_en = 1'b1; wr_win = 2'd0; wr_sel = 1'b0; wr_data = 32'h4000_0000 | 32'd28;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    mb[0] = 32'h4000_0000 | 32'd28;
    chk("R10 same-cycle old settings", {out_valid, out_miss, out_idx, out_type, out_addr}, e);
    do_req(32'h4000_0010, "R10 next request new settings");
    do_req(32'h5000_0010, "R10 aperture 0 disabled");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule